// File: doc/BRIEF.md
# Three-Operand Opcode-Selected Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes three 4-bit operands (a primary operand `a` and two alternative second sources, `b` and `m`) and a 4-bit operation code. It returns a 4-bit result. The operation code picks one of thirteen functions:

- modular addition or subtraction of `a` with `b` or with `m`;
- bitwise inversion of any one operand;
- bitwise AND, OR or XOR of `a` with `b` or with `m`.

The block has no clock, no stored state and no status outputs. The result follows the inputs within the same evaluation. The three unassigned codes give a zero result, so every input combination has a defined output.

The block is meant to sit inside a larger datapath. The surrounding logic presents the operands and the code, and takes the result combinationally. The operand width is a parameter whose default is 4. The code map is fixed.

Top module: `tri_src_alu`

## Requirements
- R1: Code 4'b0000 gives r = (a + b) mod 16, and code 4'b0001 gives r = (a + m) mod 16. The carry out of the top bit is discarded.
- R2: Code 4'b0010 gives r = (a - b) mod 16, and code 4'b0011 gives r = (a - m) mod 16. Both are formed as a plus the inverted subtrahend plus one, and the borrow is discarded.
- R3: Code 4'b0100 gives ~a, code 4'b0101 gives ~b, and code 4'b0110 gives ~m.
- R4: Code 4'b0111 gives a & b, and code 4'b1000 gives a & m.
- R5: Code 4'b1001 gives a | b, and code 4'b1010 gives a | m.
- R6: Code 4'b1011 gives a ^ b, and code 4'b1100 gives a ^ m.
- R7: Codes 4'b1101, 4'b1110 and 4'b1111 give r = 4'b0000 for any operand values.
- R8: The result depends only on the present inputs. It settles without any clock edge, and no state is held from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | Primary operand |
| b | input | 4 | First alternative second operand |
| m | input | 4 | Second alternative second operand |
| op | input | 4 | Operation code |
| r | output | 4 | Result |

## Verification
The bench first applies a few directed vectors with no clock edge between the input change and the check, which covers the settle-without-clock behaviour. It then sweeps all sixteen codes against every combination of `a`, `b` and `m`. Sums that overflow and differences that underflow show whether the carry and borrow are dropped correctly. Vectors where `b` and `m` differ show whether the wrong second source is steered in, for example `b` used where `m` was selected. The unassigned codes, swept with every operand value, show whether any operand leaks into the result.

// File: rtl/tri_src_alu_pkg.sv
package tri_src_alu_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD_B = 4'd0,
    OP_ADD_M = 4'd1,
    OP_SUB_B = 4'd2,
    OP_SUB_M = 4'd3,
    OP_INV_A = 4'd4,
    OP_INV_B = 4'd5,
    OP_INV_M = 4'd6,
    OP_AND_B = 4'd7,
    OP_AND_M = 4'd8,
    OP_OR_B  = 4'd9,
    OP_OR_M  = 4'd10,
    OP_XOR_B = 4'd11,
    OP_XOR_M = 4'd12,
    OP_RSV0  = 4'd13,
    OP_RSV1  = 4'd14,
    OP_RSV2  = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    U_ZERO  = 2'd0,
    U_ARITH = 2'd1,
    U_LOGIC = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_M = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    K_AND = 2'd0,
    K_OR  = 2'd1,
    K_XOR = 2'd2,
    K_INV = 2'd3
  } lkind_e;

  typedef struct packed {
    unit_e  unit;
    logic   sub;
    logic   use_m;
    src_e   inv_src;
    lkind_e kind;
  } ctl_t;

endpackage

// File: rtl/tsa_decode.sv
module tsa_decode
  import tri_src_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctl_t           ctl
);

  always_comb begin
    ctl = '{unit: U_ZERO, sub: 1'b0, use_m: 1'b0, inv_src: SRC_A, kind: K_AND};
    case (opcode_e'(op))
      OP_ADD_B: begin ctl.unit = U_ARITH; end
      OP_ADD_M: begin ctl.unit = U_ARITH; ctl.use_m = 1'b1; end
      OP_SUB_B: begin ctl.unit = U_ARITH; ctl.sub = 1'b1; end
      OP_SUB_M: begin ctl.unit = U_ARITH; ctl.sub = 1'b1; ctl.use_m = 1'b1; end
      OP_INV_A: begin ctl.unit = U_LOGIC; ctl.kind = K_INV; ctl.inv_src = SRC_A; end
      OP_INV_B: begin ctl.unit = U_LOGIC; ctl.kind = K_INV; ctl.inv_src = SRC_B; end
      OP_INV_M: begin ctl.unit = U_LOGIC; ctl.kind = K_INV; ctl.inv_src = SRC_M; end
      OP_AND_B: begin ctl.unit = U_LOGIC; ctl.kind = K_AND; end
      OP_AND_M: begin ctl.unit = U_LOGIC; ctl.kind = K_AND; ctl.use_m = 1'b1; end
      OP_OR_B:  begin ctl.unit = U_LOGIC; ctl.kind = K_OR; end
      OP_OR_M:  begin ctl.unit = U_LOGIC; ctl.kind = K_OR; ctl.use_m = 1'b1; end
      OP_XOR_B: begin ctl.unit = U_LOGIC; ctl.kind = K_XOR; end
      OP_XOR_M: begin ctl.unit = U_LOGIC; ctl.kind = K_XOR; ctl.use_m = 1'b1; end
      default:  begin ctl.unit = U_ZERO; end
    endcase
  end

  // The unit chosen must agree with the code range.
  always_comb begin
    if (op >= 4'd13) begin
      AST_RSV_DECODE_ZERO: assert (ctl.unit == U_ZERO)
        else $error("reserved code decoded to a live unit"); // R7
    end
    if (op <= 4'd3) begin
      AST_ARITH_RANGE: assert (ctl.unit == U_ARITH && ctl.sub == op[1] && ctl.use_m == op[0])
        else $error("arith code decoded wrongly"); // R1
    end
  end

endmodule

// File: rtl/tsa_addsub.sv
module tsa_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] s
);

  logic [W-1:0] y_eff;
  logic [W-1:0] c;

  assign y_eff = y ^ {W{sub}};
  assign c[0]  = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = x[i] ^ y_eff[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (x[i] & y_eff[i]) | (x[i] & c[i]) | (y_eff[i] & c[i]);
    end
  end

  // Inverse relations, computed independently of the ripple chain.
  logic [W-1:0] back_add;
  logic [W-1:0] back_sub;
  assign back_add = s + y;
  assign back_sub = s - y;

  always_comb begin
    if (sub) begin
      AST_SUB_INVERSE: assert (back_add == x)
        else $error("difference plus subtrahend differs from minuend"); // R2
    end else begin
      AST_ADD_INVERSE: assert (back_sub == x)
        else $error("sum minus addend differs from operand"); // R1
    end
  end

endmodule

// File: rtl/tsa_logic.sv
module tsa_logic
  import tri_src_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] q,
  input  lkind_e       kind,
  output logic [W-1:0] o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (kind)
        K_AND:   o[i] = p[i] & q[i];
        K_OR:    o[i] = p[i] | q[i];
        K_XOR:   o[i] = p[i] ^ q[i];
        default: o[i] = ~p[i];
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_AND: begin
        AST_AND_SUBSET: assert ((o & ~p) == '0 && (o & ~q) == '0 && (o | ~(p & q)) == '1)
          else $error("AND result not the common bits"); // R4
      end
      K_OR: begin
        AST_OR_COVER: assert ((o & p) == p && (o & q) == q && (o & ~(p | q)) == '0)
          else $error("OR result does not cover operands"); // R5
      end
      K_XOR: begin
        AST_XOR_UNDO: assert ((o ^ q) == p)
          else $error("XOR result does not undo"); // R6
      end
      default: begin
        AST_INV_DISJOINT: assert ((o ^ p) == '1)
          else $error("inversion leaves a bit unchanged"); // R3
      end
    endcase
  end

endmodule

// File: rtl/tri_src_alu.sv
module tri_src_alu
  import tri_src_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   m,
  input  logic [OPW-1:0] op,
  output logic [W-1:0]   r
);

  ctl_t         ctl;
  logic [W-1:0] second;
  logic [W-1:0] lp;
  logic [W-1:0] arith_out;
  logic [W-1:0] logic_out;

  tsa_decode u_dec (
    .op  (op),
    .ctl (ctl)
  );

  assign second = ctl.use_m ? m : b;

  always_comb begin
    case (ctl.inv_src)
      SRC_B:   lp = (ctl.kind == K_INV) ? b : a;
      SRC_M:   lp = (ctl.kind == K_INV) ? m : a;
      default: lp = a;
    endcase
  end

  tsa_addsub #(.W(W)) u_arith (
    .x   (a),
    .y   (second),
    .sub (ctl.sub),
    .s   (arith_out)
  );

  tsa_logic #(.W(W)) u_logic (
    .p    (lp),
    .q    (second),
    .kind (ctl.kind),
    .o    (logic_out)
  );

  always_comb begin
    case (ctl.unit)
      U_ARITH: r = arith_out;
      U_LOGIC: r = logic_out;
      default: r = '0;
    endcase
  end

  always_comb begin
    if (op >= 4'd13) begin
      AST_RSV_RESULT_ZERO: assert (r == '0)
        else $error("reserved code gave nonzero result"); // R7
    end
    if (op == 4'd4 || op == 4'd5 || op == 4'd6) begin
      AST_INV_PICKS_SOURCE: assert ((r ^ (op == 4'd4 ? a : (op == 4'd5 ? b : m))) == '1)
        else $error("inversion used wrong operand"); // R3
    end
  end

endmodule

// File: tb/tb_tri_src_alu.sv
`timescale 1ns/1ps
module tb_tri_src_alu;

  logic       clk = 1'b0;
  logic [3:0] a = '0, b = '0, m = '0, op = '0;
  logic [3:0] r;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a;
    logic [3:0] b;
    logic [3:0] m;
    logic [3:0] exp;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  tri_src_alu dut (.a(a), .b(b), .m(m), .op(op), .r(r));

  function automatic logic [3:0] model(input logic [3:0] o, input logic [3:0] x,
                                       input logic [3:0] y, input logic [3:0] z);
    int t;
    case (o)
      4'd0:  t = (int'(x) + int'(y)) % 16;
      4'd1:  t = (int'(x) + int'(z)) % 16;
      4'd2:  t = (int'(x) - int'(y) + 16) % 16;
      4'd3:  t = (int'(x) - int'(z) + 16) % 16;
      4'd4:  t = 15 - int'(x);
      4'd5:  t = 15 - int'(y);
      4'd6:  t = 15 - int'(z);
      4'd7:  t = int'(x & y);
      4'd8:  t = int'(x & z);
      4'd9:  t = int'(x | y);
      4'd10: t = int'(x | z);
      4'd11: t = int'(x ^ y);
      4'd12: t = int'(x ^ z);
      default: t = 0;
    endcase
    return t[3:0];
  endfunction

  function automatic string tag(input logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o <= 4'd3) return "R2";
    if (o <= 4'd6) return "R3";
    if (o <= 4'd8) return "R4";
    if (o <= 4'd10) return "R5";
    if (o <= 4'd12) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d m=%0d actual=%0d expected=%0d",
               req, op, a, b, m, got, exp);
    end
  endtask

  // Driver: apply one vector and queue its expected result.
  task automatic drive(input logic [3:0] o, input logic [3:0] x,
                       input logic [3:0] y, input logic [3:0] z);
    @(posedge clk);
    op = o; a = x; b = y; m = z;
    sb_q.push_back('{op: o, a: x, b: y, m: z, exp: model(o, x, y, z)});
  endtask

  // Monitor: pop and compare half a cycle after each vector is applied.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(tag(it.op), r, it.exp);
      end
    end
  end

  initial begin
    // R8: initial all-zero inputs, result visible before any clock edge.
    #1;
    check("R8", r, 4'd0);
    // R8: input changes settle with no clock edge in between.
    op = 4'd0; a = 4'd9; b = 4'd8; m = 4'd1; #0.5;
    check("R8", r, 4'd1);                 // carry dropped, R1
    op = 4'd3; #0.5;
    check("R8", r, 4'd8);
    op = 4'd15; #0.5;
    check("R8", r, 4'd0);                 // R7 with nonzero operands
    op = 4'd5; b = 4'd0; #0.5;
    check("R8", r, 4'd15);                // no memory of the earlier value
    // Exhaustive sweep through the scoreboard.
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int z = 0; z < 16; z++)
            drive(4'(o), 4'(x), 4'(y), 4'(z));
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule